// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host that can only issue byte-wide register writes and reads reach the 16-bit internal registers of a network controller. The controller offers two 16-bit targets: a register-address port, which selects one of its internal registers, and a data port, which reads or writes the selected register. The host loads two write-holding bytes and a control byte. The control byte holds the transfer direction, the target select and an active-low controller reset. The host then writes any value to a command register. The bridge runs exactly one 16-bit transfer on a strobe/acknowledge port toward the controller and reports busy in a status byte until the transfer ends.

Read results go into a read-holding register that is separate from the write-holding register. The host reads it back one byte at a time. The bridge does not interpret the controller's register indices. Sequencing rules between indirect registers remain the host software's job, so every access passes through as issued. The status byte also shows the controller's interrupt request, inverted.

Host byte map: offset 0 and 1 are the write-holding low and high bytes (write-only; they read as 0). Offset 2 and 3 are the read-holding low and high bytes (read-only). Offset 4 is control on write and status on read. Offset 5 is the command register (write-only). A read result appears on `host_rdata` one clock after `host_addr` is presented.

Top module: `idx_reg_bridge`

## Requirements
- R1: After reset, status bit 5 (busy) is 0, `ctl_req` is 0, `ctl_rst_n` is 0 (control byte cleared), and both read-holding bytes read 0.
- R2: Control bit 3 is an active-low controller reset: the clock after a control write, `ctl_rst_n` equals the written bit 3.
- R3: A write of any value to offset 5 while idle starts one transfer. On the next clock, `ctl_req` is 1 with `ctl_rd` = control bit 1 (1 reads from the controller), `ctl_sel_addr` = control bit 0 (1 targets the register-address port), and `ctl_wdata` = {offset 1 byte, offset 0 byte}.
- R4: Status bit 5 reads 1 and `ctl_req` stays 1 from the clock after the command until the clock in which `ctl_ack` is sampled. Both read 0 from the following clock.
- R5: A command write that arrives while busy is ignored: it neither changes the transfer in flight nor starts a second transfer after it completes.
- R6: A read transfer loads `ctl_rdata` into the read-holding register on the acknowledge clock. Offset 2 returns bits 7:0 and offset 3 returns bits 15:8.
- R7: A write transfer leaves the read-holding register unchanged, so reads never return the write-holding value.
- R8: Status bit 4 is active low: it reads 0 while `ctl_irq` is 1 and 1 while `ctl_irq` is 0.
- R9: Every access is forwarded unfiltered, including address-port writes of indices 1 to 3 and data writes after them, with no check of the controller's stop state.
- R10: Direction, target and write data of a transfer are held on the controller port for its whole duration, even if the host rewrites the control or write-holding bytes meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte for the previous cycle's offset |
| ctl_req | output | 1 | Transfer request toward the controller, held until acknowledge |
| ctl_rd | output | 1 | 1 = read from the controller, 0 = write to it |
| ctl_sel_addr | output | 1 | 1 = register-address port, 0 = data port |
| ctl_wdata | output | 16 | Write data of the current transfer |
| ctl_rdata | input | 16 | Controller read data, valid with `ctl_ack` |
| ctl_ack | input | 1 | Controller completes the current transfer |
| ctl_irq | input | 1 | Controller interrupt request, active high |
| ctl_rst_n | output | 1 | Active-low controller reset |

## Verification
On every cycle, assertions check the following:
- an idle command always starts a transfer;
- an acknowledge always ends it one clock later;
- the request fields stay frozen while a transfer waits;
- the read-holding register changes only on a read acknowledge;
- the reset pin and the inverted interrupt bit follow the host's control write and the controller's request.

Only the bench's scenarios can show the end-to-end results:
- byte-level assembly of write data and the split of read data across two offsets;
- a command issued during busy producing no extra transfer after completion;
- address-port writes of indices 1 to 3 passing through untouched;
- random latencies and patterns giving the right read-back values.

// File: rtl/idx_reg_bridge_pkg.sv
package idx_reg_bridge_pkg;
  localparam int BYTE_W = 8;
  localparam int NBYTES = 2;
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam int ADDR_W = 3;

  localparam int OFF_WHOLD = 0;
  localparam int OFF_RHOLD = NBYTES;
  localparam int OFF_CTRL  = 2 * NBYTES;
  localparam int OFF_CMD   = 2 * NBYTES + 1;

  localparam int CTRL_SEL_BIT  = 0;
  localparam int CTRL_RD_BIT   = 1;
  localparam int CTRL_RSTN_BIT = 3;
  localparam int STAT_IRQN_BIT = 4;
  localparam int STAT_BUSY_BIT = 5;

  typedef struct packed {
    logic rst_n;
    logic rd;
    logic sel_addr;
  } ctrl_t;
endpackage

// File: rtl/idx_reg_host_regs.sv
module idx_reg_host_regs
  import idx_reg_bridge_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [WORD_W-1:0]   wr_hold,
  output ctrl_t               ctrl,
  output logic                cmd_pulse
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) wr_hold[i*BYTE_W +: BYTE_W] <= '0;
      else if (we && addr == ADDR_W'(OFF_WHOLD + i))
        wr_hold[i*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (we && addr == ADDR_W'(OFF_CTRL)) begin
      ctrl.rst_n    <= wdata[CTRL_RSTN_BIT];
      ctrl.rd       <= wdata[CTRL_RD_BIT];
      ctrl.sel_addr <= wdata[CTRL_SEL_BIT];
    end
  end

  assign cmd_pulse = we && (addr == ADDR_W'(OFF_CMD));
endmodule

// File: rtl/idx_reg_xfer_engine.sv
module idx_reg_xfer_engine
  import idx_reg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic              start_sel,
  input  logic [WORD_W-1:0] start_wdata,
  input  logic              ack,
  input  logic [WORD_W-1:0] ack_rdata,
  output logic              busy,
  output logic              req_rd,
  output logic              req_sel,
  output logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rd_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      req_rd    <= 1'b0;
      req_sel   <= 1'b0;
      req_wdata <= '0;
      rd_hold   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        req_rd    <= start_rd;
        req_sel   <= start_sel;
        req_wdata <= start_wdata;
      end
    end else if (ack) begin
      busy <= 1'b0;
      if (req_rd) rd_hold <= ack_rdata;
    end
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && req_rd == $past(start_rd) && req_wdata == $past(start_wdata)));
  assert_done_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && ack) |=> !busy);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> (busy && $stable(req_rd) && $stable(req_sel) && $stable(req_wdata)));
  assert_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !ack) |=> $stable(req_wdata));
  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && ack && req_rd) |=> (rd_hold == $past(ack_rdata)));
  assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && ack && req_rd) |=> $stable(rd_hold));
endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import idx_reg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              ctl_req,
  output logic              ctl_rd,
  output logic              ctl_sel_addr,
  output logic [15:0]       ctl_wdata,
  input  logic [15:0]       ctl_rdata,
  input  logic              ctl_ack,
  input  logic              ctl_irq,
  output logic              ctl_rst_n
);
  logic [WORD_W-1:0] wr_hold, rd_hold;
  ctrl_t             ctrl;
  logic              cmd_pulse, busy;
  logic [BYTE_W-1:0] rd_next;

  idx_reg_host_regs u_regs (
    .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .wr_hold(wr_hold), .ctrl(ctrl), .cmd_pulse(cmd_pulse)
  );

  idx_reg_xfer_engine u_eng (
    .clk(clk), .rst(rst), .start(cmd_pulse),
    .start_rd(ctrl.rd), .start_sel(ctrl.sel_addr), .start_wdata(wr_hold),
    .ack(ctl_ack), .ack_rdata(ctl_rdata),
    .busy(busy), .req_rd(ctl_rd), .req_sel(ctl_sel_addr),
    .req_wdata(ctl_wdata), .rd_hold(rd_hold)
  );

  assign ctl_req   = busy;
  assign ctl_rst_n = ctrl.rst_n;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NBYTES; i++)
      if (host_addr == ADDR_W'(OFF_RHOLD + i)) rd_next = rd_hold[i*BYTE_W +: BYTE_W];
    if (host_addr == ADDR_W'(OFF_CTRL)) begin
      rd_next[STAT_BUSY_BIT] = busy;
      rd_next[STAT_IRQN_BIT] = ~ctl_irq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_next;
  end

  assert_rstpin_R2: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 3'(OFF_CTRL)) |=> (ctl_rst_n == $past(host_wdata[CTRL_RSTN_BIT])));
  assert_irqn_R8: assert property (@(posedge clk) disable iff (rst)
    (host_addr == 3'(OFF_CTRL)) |=> (host_rdata[STAT_IRQN_BIT] == !$past(ctl_irq)));
  assert_busybit_R4: assert property (@(posedge clk) disable iff (rst)
    (host_addr == 3'(OFF_CTRL)) |=> (host_rdata[STAT_BUSY_BIT] == $past(ctl_req)));
endmodule

// File: tb/idx_reg_bridge_tb.sv
`timescale 1ns/100ps
module idx_reg_bridge_tb;
  logic clk = 0, rst = 1;
  logic host_we = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic ctl_req, ctl_rd, ctl_sel_addr, ctl_rst_n;
  logic [15:0] ctl_wdata, ctl_rdata = 0;
  logic ctl_ack = 0, ctl_irq = 0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_rhold = 0;

  always #2.5 clk = ~clk;

  idx_reg_bridge u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(bit busy, bit irq);
    return {2'b00, busy, ~irq, 4'b0000};
  endfunction

  task automatic hwrite(logic [2:0] a, logic [7:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic hread(logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  // one full transfer with the bench acting as controller
  task automatic xfer(bit rd, bit sel, logic [15:0] wd, logic [15:0] rdv,
                      int lat, bit poke);
    logic [7:0] b, lo, hi;
    hwrite(3'd0, wd[7:0]);
    hwrite(3'd1, wd[15:8]);
    hwrite(3'd4, {4'b0000, 1'b1, 1'b0, rd, sel});
    hwrite(3'd5, 8'($urandom));
    chk("R3 req", ctl_req, 1);
    chk("R3 fields", {ctl_rd, ctl_sel_addr, ctl_wdata}, {rd, sel, wd});
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) begin
        hwrite(3'd0, ~wd[7:0]);
        hwrite(3'd4, {4'b0000, 1'b1, 1'b0, ~rd, ~sel});
        hwrite(3'd5, 8'hA5);
        chk("R10 held", {ctl_rd, ctl_sel_addr, ctl_wdata}, {rd, sel, wd});
        chk("R5 still one xfer", ctl_req, 1);
      end
      hread(3'd4, b);
      chk("R4 busy", b, status_exp(1, ctl_irq));
    end
    ctl_ack = 1; ctl_rdata = rdv;
    @(negedge clk);
    ctl_ack = 0; ctl_rdata = $urandom;
    if (rd) exp_rhold = rdv;
    chk("R4 req clears", ctl_req, 0);
    hread(3'd4, b);
    chk("R4 busy clears", b, status_exp(0, ctl_irq));
    if (poke) chk("R5 no second xfer", ctl_req, 0);
    hread(3'd2, lo);
    hread(3'd3, hi);
    chk(rd ? "R6 read hold" : "R7 read hold kept", {hi, lo}, exp_rhold);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", ctl_req, 0);
    chk("R1 rst_n", ctl_rst_n, 0);
    hread(3'd4, b); chk("R1 status", b, status_exp(0, 0));
    hread(3'd2, b); chk("R1 rhold lo", b, 0);
    hread(3'd3, b); chk("R1 rhold hi", b, 0);
    // R2 reset pin
    hwrite(3'd4, 8'h08); chk("R2 release", ctl_rst_n, 1);
    hwrite(3'd4, 8'hF7); chk("R2 assert", ctl_rst_n, 0);
    hwrite(3'd4, 8'h08); chk("R2 release again", ctl_rst_n, 1);
    // R8 interrupt bit
    ctl_irq = 1; hread(3'd4, b); chk("R8 irq active", b[4], 0);
    ctl_irq = 0; hread(3'd4, b); chk("R8 irq idle", b[4], 1);
    // R6/R7 directed: read then write leaves value
    xfer(1, 0, 16'h0000, 16'hBEEF, 0, 0);
    xfer(0, 0, 16'h1234, 16'h5555, 2, 0);
    // R9 address-port writes of indices 1..3 then data write, passed through
    for (int k = 1; k <= 3; k++) begin
      xfer(0, 1, 16'(k), 16'h0, 1, 0);
      chk("R9 index forwarded", ctl_wdata, 16'(k));
      xfer(0, 0, 16'hC0DE + 16'(k), 16'h0, 0, 0);
    end
    // R5/R10 directed command while busy
    xfer(1, 1, 16'h00AA, 16'h7E57, 3, 1);
    // random mix
    for (int n = 0; n < 150; n++) begin
      ctl_irq = 1'($urandom);
      xfer(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
           int'($urandom_range(0, 4)), ($urandom_range(0, 7) == 0) ? 1'b1 : 1'b0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule